// File: doc/BRIEF.md
# AHB Target Port Coverage Monitor

This block sits passively beside the target port of an AHB bus. It never drives the bus and never looks at data. It watches the control signals and sorts every transfer it sees into coverage totals: by transfer type, by burst kind, by transfer size and by response kind. A regression reads these totals at the end of a run to find stimulus that never happened, such as a burst kind that was never issued or a response kind that was never returned.

It also checks one timing rule. An ERROR response must take at least two cycles: one or more wait cycles that already show ERROR, then the completing cycle. If an ERROR completes with no such wait cycle, a sticky violation flag is raised. A separate counter records ERROR responses with a long wait portion, so a run can show that drawn-out error handling was exercised.

Every counter stops at its all-ones value. An active-low reset clears every counter and the flag.

Top module: `ahb_tgt_cov_mon`

## Requirements
- R1: While `rst_n` is low, every counter output and `o_err_violation` read zero.
- R2: An address phase is sampled only on a rising edge where `bus_ready` and `bus_sel` are both high. Each sampled phase adds one to `o_xfer_total`. Transfer type code 00 adds one to `o_idle_cnt` and code 01 adds one to `o_busy_cnt`. When either input is low, no address-phase counter changes.
- R3: A sampled phase with transfer type code 10 (first beat) or 11 (following beat) adds one to `o_read_cnt` when `bus_write` is 0, or to `o_write_cnt` when `bus_write` is 1.
- R4: A sampled phase with type code 10 adds one to `o_burst_cnt[k]`, where k is the 3-bit burst code. Codes 0 to 7 mean single, incrementing of open length, 4-beat wrap, 4-beat incrementing, 8-beat wrap, 8-beat incrementing, 16-beat wrap and 16-beat incrementing. Beats with code 11 are not counted here.
- R5: A sampled phase with type code 10 or 11 and size code 0, 1 or 2 (byte, halfword, word) adds one to `o_size_cnt` at that index. Other size codes and idle or busy phases leave the size counters unchanged.
- R6: A data phase exists only after a sampled phase with type code 10 or 11. It completes on the first later edge where `bus_ready` is high. At that edge, `o_resp_cnt[r]` gains one, where r is the response code: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT. With no data phase pending, the response inputs are ignored.
- R7: If an ERROR response completes and the cycle before it was not a wait cycle of the same data phase showing ERROR, `o_err_violation` goes high. It stays high until reset.
- R8: If an ERROR response completes after more than `LONG_WAITS` consecutive wait cycles showing ERROR (default 2), `o_long_err_cnt` gains one.
- R9: Each counter is `CW` bits wide. Once it holds all ones it stays there, whatever more events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Target select |
| bus_trans | input | 2 | Transfer type code |
| bus_write | input | 1 | Direction, 1 = write |
| bus_size | input | 3 | Transfer size code |
| bus_burst | input | 3 | Burst kind code |
| bus_ready | input | 1 | Transfer done / phase advance |
| bus_resp | input | 2 | Response code |
| o_xfer_total | output | CW | All sampled address phases |
| o_read_cnt | output | CW | Active read transfers |
| o_write_cnt | output | CW | Active write transfers |
| o_idle_cnt | output | CW | Idle phases |
| o_busy_cnt | output | CW | Busy phases |
| o_resp_cnt | output | 4 x CW | Completed responses, indexed by response code |
| o_burst_cnt | output | 8 x CW | Bursts started, indexed by burst code |
| o_size_cnt | output | 3 x CW | Active transfers by size code 0..2 |
| o_long_err_cnt | output | CW | ERROR responses with a long wait portion |
| o_err_violation | output | 1 | Sticky flag for an ERROR response that completed too early |

## Verification
The embedded properties take the bus inputs to be known, 0 or 1, on every rising edge after reset. They also take a pending data phase to end only through a `bus_ready` high cycle. The properties make no assumption that the manager follows the protocol: a single-cycle ERROR is a legal input, and it is exactly what the flag reports. The stimulus changes the inputs only at falling edges, holds them through each rising edge, and keeps them at defined values from time zero. It also deliberately includes protocol-breaking patterns: an early ERROR completion, an unselected target, and an unknown size code.

// File: rtl/ahbmon_pkg.sv
package ahbmon_pkg;
   typedef logic [1:0] code2_t;

   localparam code2_t TR_IDLE = 2'b00;
   localparam code2_t TR_BUSY = 2'b01;
   localparam code2_t TR_NSEQ = 2'b10;
   localparam code2_t TR_SEQ  = 2'b11;

   localparam code2_t RS_OKAY  = 2'b00;
   localparam code2_t RS_ERROR = 2'b01;
   localparam code2_t RS_RETRY = 2'b10;
   localparam code2_t RS_SPLIT = 2'b11;

   localparam int NUM_RESP  = 4;
   localparam int NUM_BURST = 8;
   localparam int NUM_SIZE  = 3;
   localparam int SIZE_W    = 3;
   localparam int BURST_W   = 3;
endpackage

// File: rtl/ahbmon_sat_cnt.sv
module ahbmon_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   if (W < 2) begin : g_bad_width
      $error("ahbmon_sat_cnt: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (inc && count != TOP)
         count <= count + W'(1);
   end

   // R9: a full counter never wraps
   a_r9_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP) |=> (count == TOP));

   // R9: a counter only ever advances by one
   a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == $past(count) + W'(1)));
endmodule

// File: rtl/ahbmon_addr_dec.sv
module ahbmon_addr_dec
   import ahbmon_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  code2_t               trans,
   input  logic                 write,
   input  logic [SIZE_W-1:0]    size,
   input  logic [BURST_W-1:0]   burst,
   input  logic                 ready,
   output logic                 total_inc,
   output logic                 idle_inc,
   output logic                 busy_inc,
   output logic                 read_inc,
   output logic                 write_inc,
   output logic [NUM_BURST-1:0] burst_inc,
   output logic [NUM_SIZE-1:0]  size_inc
);
   logic take;
   logic active;

   always_comb begin
      take      = ready && sel;
      active    = take && (trans == TR_NSEQ || trans == TR_SEQ);
      total_inc = take;
      idle_inc  = take && trans == TR_IDLE;
      busy_inc  = take && trans == TR_BUSY;
      read_inc  = active && !write;
      write_inc = active && write;
   end

   for (genvar b = 0; b < NUM_BURST; b++) begin : g_burst
      assign burst_inc[b] = take && trans == TR_NSEQ && burst == BURST_W'(b);
   end

   for (genvar s = 0; s < NUM_SIZE; s++) begin : g_size
      assign size_inc[s] = active && size == SIZE_W'(s);
   end

   // R4: at most one burst kind counted per sampled phase
   a_r4_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(burst_inc));

   // R5: a size class is only counted together with a read or write
   a_r5_size_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
      (|size_inc) |-> (read_inc || write_inc));
endmodule

// File: rtl/ahbmon_resp_trk.sv
module ahbmon_resp_trk
   import ahbmon_pkg::*;
#(
   parameter int LONG_WAITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ready,
   input  logic                addr_active,
   input  code2_t              resp,
   output logic [NUM_RESP-1:0] resp_inc,
   output logic                long_inc,
   output logic                violation
);
   localparam int EW = $clog2(LONG_WAITS + 2);
   localparam logic [EW-1:0] RUN_TOP = '1;

   if (LONG_WAITS < 1) begin : g_bad_waits
      $error("ahbmon_resp_trk: LONG_WAITS must be at least 1");
   end

   logic          pending;
   logic [EW-1:0] err_run;
   logic          finishing;
   logic          err_done;

   assign finishing = ready && pending;
   assign err_done  = finishing && resp == RS_ERROR;
   assign long_inc  = err_done && (err_run > EW'(LONG_WAITS));

   for (genvar r = 0; r < NUM_RESP; r++) begin : g_resp
      assign resp_inc[r] = finishing && resp == 2'(r);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending <= 1'b0;
      else if (ready)
         pending <= addr_active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_run <= '0;
      else if (pending && !ready && resp == RS_ERROR)
         err_run <= (err_run == RUN_TOP) ? err_run : err_run + EW'(1);
      else
         err_run <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         violation <= 1'b0;
      else if (err_done && err_run == '0)
         violation <= 1'b1;
   end

   // R7: the violation flag holds until reset
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

   // R6: responses are counted only on a ready edge, one kind at a time
   a_r6_resp_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (|resp_inc) |-> (ready && $onehot(resp_inc)));
endmodule

// File: rtl/ahb_tgt_cov_mon.sv
module ahb_tgt_cov_mon
   import ahbmon_pkg::*;
#(
   parameter int CW         = 16,
   parameter int LONG_WAITS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_sel,
   input  logic [1:0]                    bus_trans,
   input  logic                          bus_write,
   input  logic [2:0]                    bus_size,
   input  logic [2:0]                    bus_burst,
   input  logic                          bus_ready,
   input  logic [1:0]                    bus_resp,
   output logic [CW-1:0]                 o_xfer_total,
   output logic [CW-1:0]                 o_read_cnt,
   output logic [CW-1:0]                 o_write_cnt,
   output logic [CW-1:0]                 o_idle_cnt,
   output logic [CW-1:0]                 o_busy_cnt,
   output logic [NUM_RESP-1:0][CW-1:0]   o_resp_cnt,
   output logic [NUM_BURST-1:0][CW-1:0]  o_burst_cnt,
   output logic [NUM_SIZE-1:0][CW-1:0]   o_size_cnt,
   output logic [CW-1:0]                 o_long_err_cnt,
   output logic                          o_err_violation
);
   localparam int NUM_SCALAR = 5;

   if (CW < 2) begin : g_bad_cw
      $error("ahb_tgt_cov_mon: CW must be at least 2");
   end

   logic                 total_inc, idle_inc, busy_inc, read_inc, write_inc;
   logic [NUM_BURST-1:0] burst_inc;
   logic [NUM_SIZE-1:0]  size_inc;
   logic [NUM_RESP-1:0]  resp_inc;
   logic                 long_inc;

   ahbmon_addr_dec u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (bus_sel),
      .trans     (bus_trans),
      .write     (bus_write),
      .size      (bus_size),
      .burst     (bus_burst),
      .ready     (bus_ready),
      .total_inc (total_inc),
      .idle_inc  (idle_inc),
      .busy_inc  (busy_inc),
      .read_inc  (read_inc),
      .write_inc (write_inc),
      .burst_inc (burst_inc),
      .size_inc  (size_inc)
   );

   ahbmon_resp_trk #(.LONG_WAITS(LONG_WAITS)) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .ready       (bus_ready),
      .addr_active (read_inc || write_inc),
      .resp        (bus_resp),
      .resp_inc    (resp_inc),
      .long_inc    (long_inc),
      .violation   (o_err_violation)
   );

   logic [NUM_SCALAR-1:0]         scalar_inc;
   logic [NUM_SCALAR-1:0][CW-1:0] scalar_cnt;

   assign scalar_inc   = {busy_inc, idle_inc, write_inc, read_inc, total_inc};
   assign o_xfer_total = scalar_cnt[0];
   assign o_read_cnt   = scalar_cnt[1];
   assign o_write_cnt  = scalar_cnt[2];
   assign o_idle_cnt   = scalar_cnt[3];
   assign o_busy_cnt   = scalar_cnt[4];

   for (genvar i = 0; i < NUM_SCALAR; i++) begin : g_scalar
      ahbmon_sat_cnt #(.W(CW)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(scalar_inc[i]), .count(scalar_cnt[i]));
   end

   for (genvar r = 0; r < NUM_RESP; r++) begin : g_resp_cnt
      ahbmon_sat_cnt #(.W(CW)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(resp_inc[r]), .count(o_resp_cnt[r]));
   end

   for (genvar b = 0; b < NUM_BURST; b++) begin : g_burst_cnt
      ahbmon_sat_cnt #(.W(CW)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(burst_inc[b]), .count(o_burst_cnt[b]));
   end

   for (genvar s = 0; s < NUM_SIZE; s++) begin : g_size_cnt
      ahbmon_sat_cnt #(.W(CW)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(size_inc[s]), .count(o_size_cnt[s]));
   end

   ahbmon_sat_cnt #(.W(CW)) u_long_cnt (
      .clk(clk), .rst_n(rst_n), .inc(long_inc), .count(o_long_err_cnt));

   // R8: a long error is always also counted as an ERROR response
   a_r8_long_is_error: assert property (@(posedge clk) disable iff (!rst_n)
      long_inc |-> resp_inc[RS_ERROR]);

   // R2: an unselected or stalled cycle changes no address-phase total
   a_r2_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_ready) |=> $stable(o_xfer_total));
endmodule

// File: tb/test_ahb_tgt_cov_mon.sv
module test_ahb_tgt_cov_mon;
   localparam int CW = 16;

   typedef struct packed {
      logic       sel;
      logic [1:0] tr;
      logic       wr;
      logic [2:0] sz;
      logic [2:0] bu;
      logic       rdy;
      logic [1:0] rs;
      logic [7:0] exp_total;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'b10, 1'b0, 3'd2, 3'd0, 1'b1, 2'b00, 8'd1},
      '{1'b1, 2'b10, 1'b1, 3'd0, 3'd3, 1'b1, 2'b00, 8'd2},
      '{1'b1, 2'b11, 1'b1, 3'd0, 3'd3, 1'b1, 2'b00, 8'd3},
      '{1'b1, 2'b01, 1'b1, 3'd0, 3'd3, 1'b1, 2'b00, 8'd4},
      '{1'b1, 2'b11, 1'b1, 3'd1, 3'd3, 1'b1, 2'b00, 8'd5},
      '{1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b0, 2'b01, 8'd5},
      '{1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b01, 8'd5},
      '{1'b1, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b00, 8'd6},
      '{1'b1, 2'b10, 1'b0, 3'd2, 3'd6, 1'b0, 2'b00, 8'd6},
      '{1'b1, 2'b10, 1'b0, 3'd2, 3'd6, 1'b1, 2'b00, 8'd7},
      '{1'b1, 2'b10, 1'b0, 3'd4, 3'd1, 1'b0, 2'b10, 8'd7},
      '{1'b1, 2'b10, 1'b0, 3'd4, 3'd1, 1'b1, 2'b10, 8'd8},
      '{1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b11, 8'd8}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_write = 1'b0, bus_ready = 1'b1;
   logic [1:0] bus_trans = 2'b00, bus_resp = 2'b00;
   logic [2:0] bus_size = 3'd0, bus_burst = 3'd0;

   logic [CW-1:0] tot, rd, wr, idl, bsy, lng;
   logic [3:0][CW-1:0] rsp;
   logic [7:0][CW-1:0] bst;
   logic [2:0][CW-1:0] siz;
   logic viol;

   logic [1:0] s_tot, s_rd, s_wr, s_idl, s_bsy, s_lng;
   logic [3:0][1:0] s_rsp;
   logic [7:0][1:0] s_bst;
   logic [2:0][1:0] s_siz;
   logic s_viol;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ahb_tgt_cov_mon #(.CW(CW)) i_ahb_tgt_cov_mon (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_trans(bus_trans),
      .bus_write(bus_write), .bus_size(bus_size), .bus_burst(bus_burst),
      .bus_ready(bus_ready), .bus_resp(bus_resp),
      .o_xfer_total(tot), .o_read_cnt(rd), .o_write_cnt(wr), .o_idle_cnt(idl),
      .o_busy_cnt(bsy), .o_resp_cnt(rsp), .o_burst_cnt(bst), .o_size_cnt(siz),
      .o_long_err_cnt(lng), .o_err_violation(viol));

   ahb_tgt_cov_mon #(.CW(2)) i_sat_small (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_trans(bus_trans),
      .bus_write(bus_write), .bus_size(bus_size), .bus_burst(bus_burst),
      .bus_ready(bus_ready), .bus_resp(bus_resp),
      .o_xfer_total(s_tot), .o_read_cnt(s_rd), .o_write_cnt(s_wr), .o_idle_cnt(s_idl),
      .o_busy_cnt(s_bsy), .o_resp_cnt(s_rsp), .o_burst_cnt(s_bst), .o_size_cnt(s_siz),
      .o_long_err_cnt(s_lng), .o_err_violation(s_viol));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(input logic s, input logic [1:0] t, input logic w,
                      input logic [2:0] z, input logic [2:0] b,
                      input logic r, input logic [1:0] p);
      bus_sel = s; bus_trans = t; bus_write = w; bus_size = z;
      bus_burst = b; bus_ready = r; bus_resp = p;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_all_zero(input string req);
      chk(req, int'(tot), 0);  chk(req, int'(rd), 0);  chk(req, int'(wr), 0);
      chk(req, int'(idl), 0);  chk(req, int'(bsy), 0); chk(req, int'(lng), 0);
      chk(req, int'(viol), 0);
      for (int k = 0; k < 4; k++) chk(req, int'(rsp[k]), 0);
      for (int k = 0; k < 8; k++) chk(req, int'(bst[k]), 0);
      for (int k = 0; k < 3; k++) chk(req, int'(siz[k]), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_all_zero("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         put(VECS[i].sel, VECS[i].tr, VECS[i].wr, VECS[i].sz, VECS[i].bu,
             VECS[i].rdy, VECS[i].rs);
         chk("R2 total per vector", int'(tot), int'(VECS[i].exp_total));
      end

      chk("R2 idle", int'(idl), 1);
      chk("R2 busy", int'(bsy), 1);
      chk("R3 read", int'(rd), 3);
      chk("R3 write", int'(wr), 3);
      chk("R4 single", int'(bst[0]), 1);
      chk("R4 incr", int'(bst[1]), 1);
      chk("R4 wrap4", int'(bst[2]), 0);
      chk("R4 incr4 once per burst", int'(bst[3]), 1);
      chk("R4 wrap8", int'(bst[4]), 0);
      chk("R4 incr8", int'(bst[5]), 0);
      chk("R4 wrap16", int'(bst[6]), 1);
      chk("R4 incr16", int'(bst[7]), 0);
      chk("R5 byte", int'(siz[0]), 2);
      chk("R5 halfword", int'(siz[1]), 1);
      chk("R5 word", int'(siz[2]), 2);
      chk("R6 okay", int'(rsp[0]), 3);
      chk("R6 error", int'(rsp[1]), 1);
      chk("R6 retry", int'(rsp[2]), 1);
      chk("R6 split", int'(rsp[3]), 1);
      chk("R7 two-cycle error no flag", int'(viol), 0);
      chk("R8 short error not long", int'(lng), 0);
      chk("R9 small total saturated", int'(s_tot), 3);
      chk("R9 small read saturated", int'(s_rd), 3);

      // R8: three ERROR wait cycles
      put(1'b1, 2'b10, 1'b1, 3'd2, 3'd0, 1'b1, 2'b00);
      repeat (3) put(1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b0, 2'b01);
      put(1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b01);
      chk("R8 long error counted", int'(lng), 1);
      chk("R6 error after long", int'(rsp[1]), 2);
      chk("R7 long error no flag", int'(viol), 0);

      // R8: exactly two wait cycles is not long
      put(1'b1, 2'b10, 1'b1, 3'd2, 3'd0, 1'b1, 2'b00);
      repeat (2) put(1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b0, 2'b01);
      put(1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b01);
      chk("R8 boundary not long", int'(lng), 1);
      chk("R6 error boundary", int'(rsp[1]), 3);

      // R7: ERROR with no wait cycle
      put(1'b1, 2'b10, 1'b1, 3'd2, 3'd0, 1'b1, 2'b00);
      put(1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b01);
      chk("R7 single-cycle error flagged", int'(viol), 1);
      chk("R6 error count", int'(rsp[1]), 4);
      repeat (2) put(1'b0, 2'b00, 1'b0, 3'd0, 3'd0, 1'b1, 2'b00);
      chk("R7 flag sticky", int'(viol), 1);
      chk("R6 no phase ignored", int'(rsp[0]), 3);
      chk("R2 total after directed", int'(tot), 11);
      chk("R9 small total held", int'(s_tot), 3);

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk_all_zero("R1 mid-run reset");
      chk("R1 small flag cleared", int'(s_viol), 0);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule